// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is a single timer channel that drives one pulse-width-modulated pin. A 16-bit up-counter advances on ticks from a power-of-four prescaler. The prescaler is fed by either the system clock or an external tick input. Each time the counter closes a period it returns to zero, and the period-complete flag pulses for one clock.

The pin is inactive while the counter is below the duty register and active from there to the end of the period. Software therefore loads the duty register with the period minus the wanted active time. A polarity bit can invert the pin.

Software programs the channel through a plain write port. The port has a two-bit register select and a 16-bit data word, and it reaches four registers: the counter, the duty, the period and the control register. A separate counter-enable input starts and stops counting. Turning the output off works in one of two ways, chosen by a control bit:
- abrupt: the pin drops to its idle level straight away;
- graceful: the pin keeps following the compare until the running period ends.

When the channel is shut down, software clears the output enable first and stops the counter only after that.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset the counter, duty, period and control registers are all zero, and both `pwm_out` and `period_done` are low.
- R2: A write with `wr_sel` = 0 loads the counter with `wr_data` directly. A write with `wr_sel` = 1 or 2 loads the duty or the period and also clears the counter to 0. A write with `wr_sel` = 3 loads the control register from `wr_data[6:0]`.
- R3: Control bits [2:0] select the prescale divide, 4 to the power of that value (1, 4, 16, 64, 256, 1024). Values 6 and 7 act as 5. The prescale phase restarts on every control write and whenever counting is disabled.
- R4: On each prescaled tick the counter increments. When the next value would equal the period, it returns to 0 instead, and `period_done` is high for exactly the following clock cycle.
- R5: The uninverted output is active while the counter is at or above the duty value. With duty below period, the output is therefore active for period minus duty ticks of every period.
- R6: Control bit 5 selects polarity. The pin equals the uninverted output XOR this bit, and the idle (inactive) level equals this bit.
- R7: Control bit 4 enables the output, independently of counting. Once it is written as 1, the pin follows the compare from the next cycle on.
- R8: With control bit 6 set, a control write that clears bit 4 puts the pin at its idle level in the next cycle.
- R9: With control bit 6 clear, clearing bit 4 leaves the pin following the compare until the counter next returns to 0, and only then goes idle. If counting is stopped before that happens, the pin keeps following the frozen compare.
- R10: Control bit 3 selects the prescaler source. When it is 0 the prescaler counts every clock; when it is 1 it counts only cycles with `ext_tick` high.
- R11: While `cnt_en` is low the counter does not advance (writes still apply), and `period_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | External tick, one prescaler input per high cycle when selected |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 counter, 1 duty, 2 period, 3 control |
| wr_data | input | 16 | Write data |
| cnt_en | input | 1 | Counter enable |
| pwm_out | output | 1 | PWM pin |
| period_done | output | 1 | One-cycle pulse after the counter returns to 0 |

## Verification
Every write, tick and enable change acts at the rising edge where it is sampled. The pin and the flag show the result one edge after the stimulus, because both come straight from registers with no further stage. The bench drives inputs on falling edges and advances its reference model on the rising edge, on the same inputs the design sees. It then compares the pin and the flag on the next falling edge, exactly one edge after the stimulus. The directed measurements of the pulse interval and the active-cycle count start from a falling edge on which the flag was seen. From that edge the counter is known to be 0, so the counting windows line up with whole periods.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int SEL_W = 3;

    typedef struct packed {
        logic             abrupt;  // bit 6
        logic             pol;     // bit 5
        logic             oe;      // bit 4
        logic             src;     // bit 3
        logic [SEL_W-1:0] sel;     // bits 2:0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        REG_CNT  = 2'd0,
        REG_DUTY = 2'd1,
        REG_PER  = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int SEL_W = 3,
    parameter int STEPS = 6,
    localparam int DIV_W = (2 * (STEPS - 1) > 0) ? 2 * (STEPS - 1) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_tick,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(STEPS - 1);

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } pre_st_t;

    pre_st_t          st_q, st_d;
    logic [SEL_W-1:0] sel_eff;
    logic [DIV_W-1:0] limit;

    always_comb begin
        sel_eff = (sel > SEL_MAX) ? SEL_MAX : sel;
        limit   = '0;
        for (int i = 0; i < STEPS; i++) begin
            if (sel_eff == SEL_W'(i)) limit = DIV_W'((64'd1 << (2 * i)) - 64'd1);
        end
        tick = run && src_tick && (st_q.phase == limit);
        st_d = st_q;
        if (restart || !run) begin
            st_d.phase = '0;
        end else if (src_tick) begin
            st_d.phase = tick ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clear,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic [CNT_W-1:0] count,
    output logic             wrap_now,
    output logic             raw_active,
    output logic             done
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             done;
    } cnt_st_t;

    cnt_st_t          st_q, st_d;
    logic [CNT_W-1:0] next_up;

    always_comb begin
        next_up  = st_q.count + 1'b1;
        wrap_now = tick && (next_up == period);
        st_d      = st_q;
        st_d.done = wrap_now;
        if (load_en)       st_d.count = load_val;
        else if (clear)    st_d.count = '0;
        else if (wrap_now) st_d.count = '0;
        else if (tick)     st_d.count = next_up;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count      = st_q.count;
    assign done       = st_q.done;
    assign raw_active = (st_q.count >= duty);

endmodule

// File: rtl/pwm_outgate.sv
module pwm_outgate (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_next,
    input  logic abrupt_next,
    input  logic pol,
    input  logic wrap_now,
    input  logic raw_active,
    output logic pin
);
    typedef struct packed {
        logic run;
    } gate_st_t;

    gate_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (oe_next)          st_d.run = 1'b1;
        else if (abrupt_next) st_d.run = 1'b0;
        else if (wrap_now)    st_d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin = st_q.run ? (raw_active ^ pol) : pol;

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int STEPS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cnt_en,
    output logic             pwm_out,
    output logic             period_done
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] period;
    } regs_t;

    regs_t            regs_q, regs_d;
    logic             wr_cnt, wr_duty, wr_per, wr_ctrl;
    logic             src_tick, tick, wrap_now, raw_active;
    logic [CNT_W-1:0] count_w, duty_w, period_w;

    always_comb begin
        wr_cnt   = wr_en && (reg_sel_e'(wr_sel) == REG_CNT);
        wr_duty  = wr_en && (reg_sel_e'(wr_sel) == REG_DUTY);
        wr_per   = wr_en && (reg_sel_e'(wr_sel) == REG_PER);
        wr_ctrl  = wr_en && (reg_sel_e'(wr_sel) == REG_CTRL);
        regs_d   = regs_q;
        if (wr_duty) regs_d.duty   = wr_data;
        if (wr_per)  regs_d.period = wr_data;
        if (wr_ctrl) regs_d.ctrl   = ctrl_t'(wr_data[CTRL_W-1:0]);
        src_tick = regs_q.ctrl.src ? ext_tick : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign duty_w   = regs_q.duty;
    assign period_w = regs_q.period;

    pwm_prescale #(.SEL_W(SEL_W), .STEPS(STEPS)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cnt_en),
        .src_tick (src_tick),
        .restart  (wr_ctrl),
        .sel      (regs_q.ctrl.sel),
        .tick     (tick)
    );

    pwm_count #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_en    (wr_cnt),
        .load_val   (wr_data),
        .clear      (wr_duty || wr_per),
        .period     (regs_q.period),
        .duty       (regs_q.duty),
        .count      (count_w),
        .wrap_now   (wrap_now),
        .raw_active (raw_active),
        .done       (period_done)
    );

    pwm_outgate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .oe_next     (regs_d.ctrl.oe),
        .abrupt_next (regs_d.ctrl.abrupt),
        .pol         (regs_q.ctrl.pol),
        .wrap_now    (wrap_now),
        .raw_active  (raw_active),
        .pin         (pwm_out)
    );

endmodule

// File: rtl/pwm_timer_chan_chk.sv
module pwm_timer_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             cnt_en,
    input logic             pwm_out,
    input logic             period_done,
    input logic [CNT_W-1:0] cnt_v
);
    // R2: a duty or period load leaves the counter at zero
    a_r2_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == 2'd1 || wr_sel == 2'd2)) |=> (cnt_v == '0));

    // R2: a direct counter load takes the written value
    a_r2_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (cnt_v == $past(wr_data)));

    // R4: the flag is raised only with the counter back at zero
    a_r4_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (period_done && !$past(wr_en)) |-> (cnt_v == '0));

    // R8: abrupt turn-off gives the idle level on the next cycle
    a_r8_abrupt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3 && !wr_data[4] && wr_data[6]) |=> (pwm_out == $past(wr_data[5])));

    // R11: no counting and no flag while disabled
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_en) |=> ($stable(cnt_v) && !period_done));

endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .cnt_en      (cnt_en),
    .pwm_out     (pwm_out),
    .period_done (period_done),
    .cnt_v       (count_w)
);

// File: tb/pwm_timer_chan_test.sv
module pwm_timer_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        cnt_en = 1'b0;
    logic        pwm_out, period_done;

    int    total = 0;
    int    bad = 0;
    bit    live = 1'b0;
    bit    finished = 1'b0;
    string tag = "R1";

    always #5 clk = ~clk;

    pwm_timer_chan uut (
        .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .cnt_en(cnt_en),
        .pwm_out(pwm_out), .period_done(period_done)
    );

    // reference model, built from the requirements
    logic [15:0] m_cnt, m_duty, m_per;
    logic [9:0]  m_pre;
    logic [6:0]  m_ctrl;
    logic        m_run, m_done;

    function automatic int div_lim(logic [2:0] s);
        int e;
        e = (s > 3'd5) ? 5 : int'(s);
        return (1 << (2 * e)) - 1;
    endfunction

    function automatic logic exp_pin();
        logic pol;
        pol = m_ctrl[5];
        return m_run ? ((m_cnt >= m_duty) ^ pol) : pol;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0; m_duty <= '0; m_per <= '0; m_pre <= '0;
            m_ctrl <= '0; m_run <= 1'b0; m_done <= 1'b0;
        end else begin
            logic src, tk, wrap, wctl;
            logic [6:0] nctl;
            logic [15:0] up;
            src  = m_ctrl[3] ? ext_tick : 1'b1;
            tk   = cnt_en && src && (int'(m_pre) == div_lim(m_ctrl[2:0]));
            up   = m_cnt + 16'd1;
            wrap = tk && (up == m_per);
            wctl = wr_en && wr_sel == 2'd3;
            nctl = wctl ? wr_data[6:0] : m_ctrl;
            m_ctrl <= nctl;
            if (wctl || !cnt_en) m_pre <= '0;
            else if (src)        m_pre <= tk ? 10'd0 : m_pre + 10'd1;
            if (wr_en && wr_sel == 2'd1) m_duty <= wr_data;
            if (wr_en && wr_sel == 2'd2) m_per <= wr_data;
            if (wr_en && wr_sel == 2'd0) m_cnt <= wr_data;
            else if (wr_en && (wr_sel == 2'd1 || wr_sel == 2'd2)) m_cnt <= '0;
            else if (wrap) m_cnt <= '0;
            else if (tk)   m_cnt <= up;
            m_done <= wrap;
            if (nctl[4])      m_run <= 1'b1;
            else if (nctl[6]) m_run <= 1'b0;
            else if (wrap)    m_run <= 1'b0;
        end
    end

    task automatic chk(string t, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live && rst_n) begin
            chk({tag, " pin"}, int'(pwm_out), int'(exp_pin()));
            chk({tag, " done"}, int'(period_done), int'(m_done));
        end
    end

    task automatic wr(logic [1:0] s, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] mk(int sel, bit src, bit oe, bit pol, bit ab);
        return {9'd0, ab, pol, oe, src, 3'(sel)};
    endfunction

    task automatic wait_done();
        do @(negedge clk); while (!period_done);
    endtask

    task automatic measure(int n, output int highs, output int dones);
        highs = 0; dones = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            highs += int'(pwm_out);
            dones += int'(period_done);
        end
    endtask

    task automatic interval(output int cyc);
        wait_done();
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!period_done);
    endtask

    initial begin
        int h, d, c;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);
        chk("R1 pin after reset", int'(pwm_out), 0);
        chk("R1 done after reset", int'(period_done), 0);

        // R4 R5 R7: divide by 1, period 10, duty 4
        tag = "R5";
        wr(2'd1, 16'd4);
        wr(2'd2, 16'd10);
        wr(2'd3, mk(0, 0, 1, 0, 1));
        cnt_en = 1'b1;
        wait_done();
        measure(10, h, d);
        chk("R5 active cycles per period", h, 6);
        chk("R4 flags per period", d, 1);
        interval(c);
        chk("R4 flag interval", c, 10);

        // R3: divide by 4, period 5, duty 2
        tag = "R3";
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd5);
        wr(2'd3, mk(1, 0, 1, 0, 1));
        wait_done();
        measure(20, h, d);
        chk("R3 active cycles at divide 4", h, 12);
        interval(c);
        chk("R3 interval at divide 4", c, 20);

        // R6: inverted polarity
        tag = "R6";
        wr(2'd1, 16'd4);
        wr(2'd2, 16'd10);
        wr(2'd3, mk(0, 0, 1, 1, 1));
        wait_done();
        measure(10, h, d);
        chk("R6 high cycles inverted", h, 4);

        // R8: abrupt turn-off, idle level high
        tag = "R8";
        wr(2'd3, mk(0, 0, 0, 1, 1));
        chk("R8 idle after abrupt off", int'(pwm_out), 1);
        measure(12, h, d);
        chk("R8 stays idle", h, 12);

        // R9: graceful turn-off with duty 0 (always active)
        tag = "R9";
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd10);
        wr(2'd3, mk(0, 0, 1, 0, 0));
        wait_done();
        wr(2'd3, mk(0, 0, 0, 0, 0));
        chk("R9 pin still active after off", int'(pwm_out), 1);
        wait_done();
        chk("R9 pin idle at period end", int'(pwm_out), 0);

        // R2: direct counter load and clear on period load
        tag = "R2";
        wr(2'd3, mk(0, 0, 1, 0, 1));
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd20);
        wr(2'd0, 16'd17);
        interval(c);
        chk("R2 interval after direct load", c, 20);

        // R11: counting stopped
        tag = "R11";
        cnt_en = 1'b0;
        measure(30, h, d);
        chk("R11 no flag while stopped", d, 0);
        cnt_en = 1'b1;

        // R3: select 7 behaves as 5
        tag = "R3";
        wr(2'd1, 16'd1);
        wr(2'd2, 16'd2);
        wr(2'd3, mk(7, 0, 1, 0, 1));
        interval(c);
        chk("R3 select 7 acts as divide 1024", c, 2048);

        // R10: external source
        tag = "R10";
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd6);
        wr(2'd3, mk(0, 1, 1, 0, 1));
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            ext_tick = ($urandom % 3) == 0;
        end
        ext_tick = 1'b0;
        measure(40, h, d);
        chk("R10 no flag without ext ticks", d, 0);

        // random mix, checked by the model each cycle
        tag = "R4 random";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            ext_tick = $urandom % 2;
            cnt_en = ($urandom % 10) != 0;
            wr_en = ($urandom % 16) == 0;
            wr_sel = 2'($urandom % 4);
            if (wr_sel == 2'd3) wr_data = {9'd0, 4'($urandom), 3'($urandom % 3)};
            else                wr_data = 16'($urandom % 24);
        end
        wr_en = 1'b0;
        repeat (4) @(negedge clk);

        live = 1'b0;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule